// File: doc/BRIEF.md
# Consecutive-Cycle Digital Lock Detector

This block decides whether a phase-locked loop has settled. On each phase-detector cycle it receives one single-cycle pulse marking the divided reference edge and one marking the divided feedback edge. It counts the ticks of its own fast sampling clock between the two pulses, whichever comes first. The resulting count is the phase error of that cycle.

Each error is sorted into one of three classes: good (below a set threshold), marginal (between the thresholds), or bad (above a clear threshold, or the second edge never arrived). The lock flag rises after three or five good cycles in a row, as chosen by a precision input. Once the flag is high, only a bad cycle drops it. The gap between the two thresholds gives hysteresis. A clear request, raised on power-down or on a counter reset, wipes the flag and the running count.

Top module: `lock_detector`

## Requirements
- R1: After synchronous active-low reset, `lock` is low.
- R2: With `precise_sel` = 0, `lock` rises after three consecutive measured cycles whose error is below SET_TICKS (default 4). It stays low after only two.
- R3: With `precise_sel` = 1, five consecutive such cycles are needed. After four, `lock` is still low.
- R4: While `lock` is high, a single cycle with error above CLR_TICKS (default 6) drives `lock` low.
- R5: While `lock` is high, a cycle with error from SET_TICKS to CLR_TICKS inclusive leaves `lock` high.
- R6: While `lock` is low, any cycle with error not below SET_TICKS restarts the consecutive count from zero.
- R7: If the second edge has not arrived TIMEOUT_TICKS (default 64) ticks after the first, the cycle ends and counts as bad. `lock` does not fall before that point.
- R8: A `clear_req` pulse drives `lock` low on the next edge and empties the consecutive count.
- R9: The error is the tick distance between the edges regardless of which one leads. Edges that arrive in the same tick measure zero.
- R10: When the edge that completes a qualifying cycle is sampled at clock edge k, `lock` changes after clock edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; one tick of phase-error resolution |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_edge | input | 1 | One-tick pulse at each divided reference edge |
| fb_edge | input | 1 | One-tick pulse at each divided feedback edge |
| precise_sel | input | 1 | 0: three good cycles to lock; 1: five |
| clear_req | input | 1 | Power-down or counter-reset clear of flag and count |
| lock | output | 1 | Active-high lock indication |

## Verification
The assertions assume that the edge pulses are synchronous, one tick wide, and separated by idle gaps. This means no new phase-detector cycle begins in the tick that closes the previous one. They also assume that `precise_sel` does not change while a count is in progress. The stimulus drives every pulse on the falling clock edge and leaves at least three idle ticks between cycles. It also sets the precision only while the block is in reset or cleared.

// File: rtl/lock_detector_pkg.sv
// Shared types for the lock detector: the class given to each measured cycle.
package lock_detector_pkg;
    typedef enum logic [1:0] {
        ERR_GOOD = 2'd0,   // error below set threshold
        ERR_MID  = 2'd1,   // between thresholds, inclusive
        ERR_BAD  = 2'd2    // above clear threshold or timed out
    } err_class_e;
endpackage

// File: rtl/phase_err_meter.sv
// Measures ticks between a reference and a feedback edge pulse, either order.
// Assumes single-tick pulses and no new cycle beginning in the tick that
// closes the previous measurement. Emits one done pulse per cycle.
module phase_err_meter #(
    parameter int TIMEOUT_TICKS = 64,
    localparam int CW = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ref_edge,
    input  logic          fb_edge,
    output logic          done,
    output logic [CW-1:0] err,
    output logic          timed_out
);
    typedef enum logic {M_IDLE, M_ARMED} meter_state_e;

    meter_state_e  state;
    logic          ref_led;
    logic [CW-1:0] ticks;
    logic          partner;

    // The edge that closes the window is the one that did not open it.
    assign partner = ref_led ? fb_edge : ref_edge;

    // Window tracking: open on first edge, close on partner or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state     <= M_IDLE;
            ref_led   <= 1'b0;
            ticks     <= '0;
            done      <= 1'b0;
            err       <= '0;
            timed_out <= 1'b0;
        end else begin
            done      <= 1'b0;
            timed_out <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (ref_edge && fb_edge) begin
                        done <= 1'b1;
                        err  <= '0;
                    end else if (ref_edge || fb_edge) begin
                        state   <= M_ARMED;
                        ref_led <= ref_edge;
                        ticks   <= CW'(1);
                    end
                end
                M_ARMED: begin
                    if (partner) begin
                        done  <= 1'b1;
                        err   <= ticks;
                        state <= M_IDLE;
                    end else if (ticks == CW'(TIMEOUT_TICKS)) begin
                        done      <= 1'b1;
                        timed_out <= 1'b1;
                        err       <= ticks;
                        state     <= M_IDLE;
                    end else begin
                        ticks <= ticks + CW'(1);
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/err_classifier.sv
// Sorts one measured error into good, marginal or bad. Pure combinational.
// Assumes SET_TICKS <= CLR_TICKS < TIMEOUT_TICKS.
module err_classifier
    import lock_detector_pkg::*;
#(
    parameter int SET_TICKS     = 4,
    parameter int CLR_TICKS     = 6,
    parameter int TIMEOUT_TICKS = 64,
    localparam int CW = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic [CW-1:0] err,
    input  logic          timed_out,
    output err_class_e    cls
);
    // Threshold compare: timeout dominates, then upper, then lower bound.
    always_comb begin
        if (timed_out || err > CW'(CLR_TICKS))
            cls = ERR_BAD;
        else if (err < CW'(SET_TICKS))
            cls = ERR_GOOD;
        else
            cls = ERR_MID;
    end
endmodule

// File: rtl/lock_qualifier.sv
// Counts consecutive good cycles and holds the lock flag with hysteresis.
// Assumes precise_sel is steady while a count is running.
module lock_qualifier
    import lock_detector_pkg::*;
#(
    parameter int COUNT_LO = 3,
    parameter int COUNT_HI = 5,
    localparam int QW = $clog2(COUNT_HI + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       valid,
    input  err_class_e cls,
    input  logic       precise_sel,
    output logic       lock
);
    logic [QW-1:0] streak;
    logic [QW-1:0] need;
    logic [QW-1:0] streak_nxt;

    // Target streak length picked by the precision input.
    assign need       = precise_sel ? QW'(COUNT_HI) : QW'(COUNT_LO);
    assign streak_nxt = streak + QW'(1);

    // Flag and streak update, once per measured cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lock   <= 1'b0;
            streak <= '0;
        end else if (valid) begin
            if (lock) begin
                if (cls == ERR_BAD) lock <= 1'b0;
                streak <= '0;
            end else if (cls == ERR_GOOD) begin
                if (streak_nxt >= need) begin
                    lock   <= 1'b1;
                    streak <= '0;
                end else begin
                    streak <= streak_nxt;
                end
            end else begin
                streak <= '0;
            end
        end
    end
endmodule

// File: rtl/lock_detector.sv
// Digital lock detector: measures reference/feedback edge skew in sampling
// ticks and qualifies lock over consecutive cycles with hysteresis.
// Assumes edge inputs are synchronous single-tick pulses.
module lock_detector
    import lock_detector_pkg::*;
#(
    parameter int SET_TICKS     = 4,
    parameter int CLR_TICKS     = 6,
    parameter int TIMEOUT_TICKS = 64,
    parameter int COUNT_LO      = 3,
    parameter int COUNT_HI      = 5,
    localparam int CW = $clog2(TIMEOUT_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_edge,
    input  logic fb_edge,
    input  logic precise_sel,
    input  logic clear_req,
    output logic lock
);
    logic          meas_valid;
    logic [CW-1:0] meas_err;
    logic          meas_to;
    err_class_e    meas_class;

    phase_err_meter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_meter (
        .clk(clk), .rst_n(rst_n), .clr(clear_req),
        .ref_edge(ref_edge), .fb_edge(fb_edge),
        .done(meas_valid), .err(meas_err), .timed_out(meas_to)
    );

    err_classifier #(
        .SET_TICKS(SET_TICKS), .CLR_TICKS(CLR_TICKS),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) u_class (
        .err(meas_err), .timed_out(meas_to), .cls(meas_class)
    );

    lock_qualifier #(.COUNT_LO(COUNT_LO), .COUNT_HI(COUNT_HI)) u_qual (
        .clk(clk), .rst_n(rst_n), .clr(clear_req),
        .valid(meas_valid), .cls(meas_class),
        .precise_sel(precise_sel), .lock(lock)
    );
endmodule

// File: rtl/lock_detector_chk.sv
// Temporal checks on the lock detector, bound to every instance of the top.
module lock_detector_chk
    import lock_detector_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       clear_req,
    input logic       meas_valid,
    input err_class_e meas_class,
    input logic       lock
);
    p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !lock);

    p_rise_on_good_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> ($past(meas_valid) && $past(meas_class) == ERR_GOOD));

    p_bad_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && meas_valid && meas_class == ERR_BAD) |=> !lock);

    p_mid_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && meas_valid && meas_class == ERR_MID && !clear_req) |=> lock);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_req |=> !lock);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!meas_valid && !clear_req) |=> $stable(lock));
endmodule

bind lock_detector lock_detector_chk u_chk (
    .clk(clk), .rst_n(rst_n), .clear_req(clear_req),
    .meas_valid(meas_valid), .meas_class(meas_class), .lock(lock)
);

// File: tb/sim_lock_detector.sv
// Directed bench for the lock detector; one task per scenario.
module sim_lock_detector;
    localparam int TO = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_edge = 1'b0;
    logic fb_edge = 1'b0;
    logic precise_sel = 1'b0;
    logic clear_req = 1'b0;
    logic lock;

    int n_checks = 0;
    int n_fail = 0;

    lock_detector u0 (
        .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .fb_edge(fb_edge),
        .precise_sel(precise_sel), .clear_req(clear_req), .lock(lock)
    );

    always #2 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lock=%0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic fresh(input logic prec);
        @(negedge clk);
        rst_n = 1'b0;
        precise_sel = prec;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One phase-detector cycle with d ticks between edges, then idle.
    task automatic pd_cycle(input int d, input logic fb_first);
        @(negedge clk);
        if (d == 0) begin ref_edge = 1'b1; fb_edge = 1'b1; end
        else if (fb_first) fb_edge = 1'b1;
        else ref_edge = 1'b1;
        @(negedge clk);
        ref_edge = 1'b0; fb_edge = 1'b0;
        if (d > 0) begin
            repeat (d - 1) @(negedge clk);
            if (fb_first) ref_edge = 1'b1; else fb_edge = 1'b1;
            @(negedge clk);
            ref_edge = 1'b0; fb_edge = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        fresh(1'b0);
        check(lock, 1'b0, "R1 reset");
    endtask

    task automatic t_lock3();
        fresh(1'b0);
        pd_cycle(2, 1'b0); pd_cycle(3, 1'b0);
        check(lock, 1'b0, "R2 two good");
        pd_cycle(1, 1'b0);
        check(lock, 1'b1, "R2 three good");
    endtask

    task automatic t_lock5();
        fresh(1'b1);
        for (int i = 0; i < 4; i++) pd_cycle(2, 1'b0);
        check(lock, 1'b0, "R3 four good");
        pd_cycle(2, 1'b0);
        check(lock, 1'b1, "R3 five good");
    endtask

    task automatic t_bad_drop();
        fresh(1'b0);
        for (int i = 0; i < 3; i++) pd_cycle(2, 1'b0);
        pd_cycle(7, 1'b0);
        check(lock, 1'b0, "R4 error 7 drops");
    endtask

    task automatic t_mid_hold();
        fresh(1'b0);
        for (int i = 0; i < 3; i++) pd_cycle(2, 1'b0);
        pd_cycle(6, 1'b0);
        check(lock, 1'b1, "R5 error 6 holds");
        pd_cycle(4, 1'b1);
        check(lock, 1'b1, "R5 error 4 holds");
    endtask

    task automatic t_streak_break();
        fresh(1'b0);
        pd_cycle(2, 1'b0); pd_cycle(2, 1'b0);
        pd_cycle(4, 1'b0);
        pd_cycle(2, 1'b0); pd_cycle(2, 1'b0);
        check(lock, 1'b0, "R6 marginal restarts count");
        pd_cycle(2, 1'b0);
        check(lock, 1'b1, "R6 fresh three good");
    endtask

    task automatic t_timeout();
        fresh(1'b0);
        for (int i = 0; i < 3; i++) pd_cycle(2, 1'b0);
        @(negedge clk);
        ref_edge = 1'b1;
        @(negedge clk);
        ref_edge = 1'b0;
        repeat (TO - 1) @(negedge clk);
        check(lock, 1'b1, "R7 no early timeout");
        repeat (5) @(negedge clk);
        check(lock, 1'b0, "R7 timeout is bad");
    endtask

    task automatic t_clear();
        fresh(1'b0);
        for (int i = 0; i < 3; i++) pd_cycle(2, 1'b0);
        @(negedge clk); clear_req = 1'b1;
        @(negedge clk); clear_req = 1'b0;
        check(lock, 1'b0, "R8 clear drops lock");
        pd_cycle(2, 1'b0); pd_cycle(2, 1'b0);
        @(negedge clk); clear_req = 1'b1;
        @(negedge clk); clear_req = 1'b0;
        pd_cycle(2, 1'b0); pd_cycle(2, 1'b0);
        check(lock, 1'b0, "R8 clear empties count");
    endtask

    task automatic t_order();
        fresh(1'b0);
        pd_cycle(3, 1'b1); pd_cycle(0, 1'b0); pd_cycle(3, 1'b1);
        check(lock, 1'b1, "R9 feedback-first and coincident good");
        pd_cycle(8, 1'b1);
        check(lock, 1'b0, "R9 feedback-first error 8 bad");
    endtask

    task automatic t_latency();
        fresh(1'b0);
        pd_cycle(2, 1'b0); pd_cycle(2, 1'b0);
        @(negedge clk); ref_edge = 1'b1;
        @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b1;
        @(negedge clk); fb_edge = 1'b0;
        check(lock, 1'b0, "R10 not yet after sampling edge");
        @(negedge clk);
        check(lock, 1'b1, "R10 high one edge later");
    endtask

    initial begin
        t_reset();
        t_lock3();
        t_lock5();
        t_bad_drop();
        t_mid_hold();
        t_streak_break();
        t_timeout();
        t_clear();
        t_order();
        t_latency();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, lock=%0b expected completion", lock);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule